// File: doc/BRIEF.md
# Limb-Pipelined Three-Operand Adder/Subtracter

This block combines a redundant partial sum with a third wide operand. The partial sum comes in two parts: a plain `N`-bit word and a vector of coarse carry bits, one bit per limb. Coarse bit `i` has weight 2^(W·(i+1)), so it belongs to limb `i+1`. The third operand is either added or subtracted, and a per-operation mode bit selects which.

The datapath is cut into `L` limbs of `W` bits each. Limb `i` is resolved in pipeline stage `i`, and the carry out of each limb is registered before the next limb uses it. The critical path is therefore one `W`-bit addition, whatever the total width. Input limbs are skewed by delay registers so that each one reaches its stage in the same cycle as the carry it needs. Result limbs are then deskewed so that the whole word leaves together.

Subtraction adds the bitwise inverse of the operand and injects a one at the lowest limb. The two-bit `hi` output holds the value above bit `N`, so `{hi,res}` equals the exact sum plus 2^N when subtracting. A new operation can be accepted on every clock.

Top module: `limb_addsub3`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset is released, `vout` is 0.
- R2: With `sub`=0, `{hi,res}` equals `psum + Σ ccar[i]·2^(W·(i+1)) + gop`, taken modulo 2^(N+2).
- R3: With `sub`=1, `{hi,res}` equals `psum + Σ ccar[i]·2^(W·(i+1)) + 2^N − gop`, taken modulo 2^(N+2). A value of `hi`=0 marks a negative true result, that is, a borrow.
- R4: An operation sampled with `vin`=1 at a clock edge appears with `vout`=1 exactly `L` clock edges later.
- R5: Operations presented on consecutive cycles, with modes mixed freely, each produce their own correct result in order, one per cycle.
- R6: An add carry generated in limb 0 ripples through every limb: `psum` all ones plus `gop`=1 gives `res`=0 and `hi`=1.
- R7: A borrow ripples through every limb: `psum`=0 minus `gop`=1 gives `res` all ones and `hi`=0.
- R8: The top coarse carry bit `ccar[L-1]` has weight 2^N. It raises `hi` by one and leaves `res` unchanged.
- R9: A cycle with `vin`=0 gives `vout`=0 exactly `L` cycles later, and it does not disturb the results of its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| vin | input | 1 | Operation valid |
| sub | input | 1 | 1 subtracts `gop`, 0 adds it |
| psum | input | W·L | Partial-sum word |
| ccar | input | L | Coarse carries; bit i has weight 2^(W·(i+1)) |
| gop | input | W·L | Third operand |
| vout | output | 1 | Result valid |
| res | output | W·L | Aligned result, low N bits |
| hi | output | 2 | Bits N+1..N of the result (carry/borrow indicator) |

## Verification
The hard case is one stage that must handle three increments in the same cycle: the registered carry from the limb below, a coarse carry bit, and an inverted operand limb. Together these push the per-limb total past a single carry bit. The bench provokes this with all-ones partial sums, dense coarse-carry vectors and both modes, and it runs the directed ripple cases back to back. Each result is judged against a full-width sum computed in one step, so a lost or doubled carry at any limb boundary shows up in `res` or in `hi`.

// File: rtl/limb_addsub3.sv
module limb_addsub3 #(
  parameter int W = 8,
  parameter int L = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vin,
  input  logic           sub,
  input  logic [W*L-1:0] psum,
  input  logic [L-1:0]   ccar,
  input  logic [W*L-1:0] gop,
  output logic           vout,
  output logic [W*L-1:0] res,
  output logic [1:0]     hi
);
  localparam int N  = W * L;
  localparam int BW = 2 * W + 2;

  logic [1:0] cy [L];
  logic [L:0] vd;
  logic       tcc [0:L];

  assign vd[0]  = vin;
  assign tcc[0] = ccar[L-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vd[L:1] <= '0;
    else        vd[L:1] <= vd[L-1:0];

  for (genvar k = 1; k <= L; k++) begin : g_tcc
    always_ff @(posedge clk) tcc[k] <= tcc[k-1];
  end

  assign vout = vd[L];
  assign hi   = cy[L-1] + {1'b0, tcc[L]};

  for (genvar i = 0; i < L; i++) begin : g_limb
    logic [BW-1:0]  dl [0:i];
    logic [W-1:0]   ol [0:L-1-i];
    logic           ccin, xsub, xcc;
    logic [W-1:0]   xs, xg;
    logic [1:0]     cin;
    logic [W+1:0]   tot;

    if (i == 0) begin : g_c0
      assign ccin = 1'b0;
      assign cin  = {1'b0, xsub};
    end else begin : g_cn
      assign ccin = ccar[i-1];
      assign cin  = cy[i-1];
    end

    assign dl[0] = {psum[i*W +: W], gop[i*W +: W], sub, ccin};
    for (genvar k = 1; k <= i; k++) begin : g_skew
      always_ff @(posedge clk) dl[k] <= dl[k-1];
    end

    assign {xs, xg, xsub, xcc} = dl[i];
    assign tot = {2'b00, xs} + {2'b00, (xsub ? ~xg : xg)}
               + {{(W+1){1'b0}}, xcc} + {{W{1'b0}}, cin};

    always_ff @(posedge clk) begin
      ol[0] <= tot[W-1:0];
      cy[i] <= tot[W+1:W];
    end

    for (genvar k = 1; k <= L-1-i; k++) begin : g_deskew
      always_ff @(posedge clk) ol[k] <= ol[k-1];
    end

    assign res[i*W +: W] = ol[L-1-i];
  end
endmodule

module limb_addsub3_chk #(
  parameter int W = 8,
  parameter int L = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           vin,
  input logic           sub,
  input logic [W*L-1:0] psum,
  input logic [L-1:0]   ccar,
  input logic [W*L-1:0] gop,
  input logic           vout,
  input logic [W*L-1:0] res,
  input logic [1:0]     hi
);
  localparam int N  = W * L;
  localparam int CW = $clog2(L + 2) + 1;

  logic [N+1:0] ed [0:L];
  logic [CW-1:0] infl;

  always_comb begin
    ed[0] = {2'b00, psum};
    for (int i = 0; i < L; i++)
      if (ccar[i]) ed[0] = ed[0] + ((N+2)'(1) << (W * (i + 1)));
    if (sub) ed[0] = ed[0] + ((N+2)'(1) << N) - {2'b00, gop};
    else     ed[0] = ed[0] + {2'b00, gop};
  end

  for (genvar k = 1; k <= L; k++) begin : g_ed
    always_ff @(posedge clk) ed[k] <= ed[k-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) infl <= '0;
    else        infl <= infl + CW'(vin) - CW'(vout);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !vout); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) vout |-> infl != '0); // R9
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) infl <= CW'(L)); // R4
  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) vout |-> {hi, res} == ed[L]); // R2 R3
endmodule

bind limb_addsub3 limb_addsub3_chk #(.W(W), .L(L)) u_chk (
  .clk(clk), .rst_n(rst_n), .vin(vin), .sub(sub), .psum(psum), .ccar(ccar),
  .gop(gop), .vout(vout), .res(res), .hi(hi)
);

// File: tb/tb_limb_addsub3.sv
module tb_limb_addsub3;
  localparam int W = 8;
  localparam int L = 4;
  localparam int N = W * L;

  logic clk = 1'b0, rst_n = 1'b0, vin = 1'b0, sub = 1'b0;
  logic [N-1:0] psum = '0, gop = '0;
  logic [L-1:0] ccar = '0;
  logic vout;
  logic [N-1:0] res;
  logic [1:0] hi;

  int total = 0, bad = 0, n = 0;
  logic         sv [16];
  logic [N+1:0] se [16];
  string        st [16];

  always #4 clk = ~clk;

  limb_addsub3 #(.W(W), .L(L)) dut (
    .clk(clk), .rst_n(rst_n), .vin(vin), .sub(sub), .psum(psum), .ccar(ccar),
    .gop(gop), .vout(vout), .res(res), .hi(hi)
  );

  function automatic logic [N+1:0] ref_val(logic [N-1:0] s, logic [L-1:0] c,
                                           logic [N-1:0] g, logic sb);
    logic [N+1:0] a = {2'b00, s};
    for (int i = 0; i < L; i++) if (c[i]) a = a + ((N+2)'(1) << (W * (i + 1)));
    if (sb) a = a + ((N+2)'(1) << N) - {2'b00, g};
    else    a = a + {2'b00, g};
    return a;
  endfunction

  task automatic chk(bit ok, string tag, logic [N+1:0] act, logic [N+1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [N-1:0] s, logic [L-1:0] c, logic [N-1:0] g,
                      logic sb, string tag);
    int slot;
    @(negedge clk);
    slot = n % 16;
    chk(vout == sv[slot], {st[slot], " (R4 valid timing)"}, {{(N+1){1'b0}}, vout},
        {{(N+1){1'b0}}, sv[slot]});
    if (sv[slot] && vout) chk({hi, res} == se[slot], st[slot], {hi, res}, se[slot]);
    sv[slot] = 1'b0;
    slot = (n + L) % 16;
    sv[slot] = v;
    se[slot] = ref_val(s, c, g, sb);
    st[slot] = tag;
    vin = v; psum = s; ccar = c; gop = g; sub = sb;
    n++;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin sv[i] = 1'b0; se[i] = '0; st[i] = "R9"; end
    repeat (3) @(negedge clk);
    chk(vout == 1'b0, "R1 in reset", {{(N+1){1'b0}}, vout}, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(vout == 1'b0, "R1 after release", {{(N+1){1'b0}}, vout}, '0);
    step(1'b1, '1, '0, 32'd1, 1'b0, "R6 add ripple");
    step(1'b1, '0, '0, 32'd1, 1'b1, "R7 borrow ripple");
    step(1'b1, '0, 4'b1000, '0, 1'b0, "R8 top coarse bit");
    step(1'b0, '1, '1, '1, 1'b1, "R9 bubble");
    step(1'b1, 32'h1234_5678, 4'b0101, 32'h0FED_CBA9, 1'b0, "R2 add");
    step(1'b1, 32'h1234_5678, 4'b0000, 32'h1234_5678, 1'b1, "R3 equal sub");
    step(1'b1, '1, '1, '1, 1'b0, "R2 max add");
    step(1'b1, '1, '1, '0, 1'b1, "R3 max sub");
    step(1'b1, '0, '0, '1, 1'b1, "R3 min sub");
    step(1'b0, '0, '0, '0, 1'b0, "R9 bubble");
    step(1'b0, '0, '0, '0, 1'b0, "R9 bubble");
    for (int j = 0; j < 600; j++) begin
      logic [N-1:0] s = N'($urandom);
      logic [N-1:0] g = N'($urandom);
      logic [L-1:0] c = L'($urandom);
      logic sb = 1'($urandom);
      logic v = ($urandom % 8) != 0;
      if (j % 13 == 0) s = '1;
      if (j % 17 == 0) c = '1;
      step(v, s, c, g, sb, v ? (sb ? "R5 R3 random sub" : "R5 R2 random add") : "R9 random bubble");
    end
    for (int j = 0; j < L + 2; j++) step(1'b0, '0, '0, '0, 1'b0, "R9 drain");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule